// File: doc/BRIEF.md
# Masked Zero-Run Counter

This execution unit takes a 64-bit operand and a 64-bit selection mask. It counts the zeros of the operand only at the bit positions the mask selects. Counting starts at one end of the word and stops at the first selected position that holds a one. A direction input picks the starting end: the most significant bit (leading) or the least significant bit (trailing). Positions the mask leaves out are skipped. They are never counted, and they never stop the count. If no selected position holds a one, the result is the number of bits set in the mask.

Operands enter on a valid/ready stream. One output register stage returns the 7-bit result on a second valid/ready stream, zero-extended to 64 bits.

Back-pressure works as follows:
- An input transfer takes place on a rising clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output stage is empty or being drained in that same cycle. A new operand can therefore follow a consumed result with no gap.
- While `out_valid` is high and `out_ready` is low, the held result stays frozen and no input is taken.

Top module: `mzc_unit`

## Requirements
- R1: Source bits at positions where the mask bit is 0 have no effect on the result.
- R2: With `in_trail` = 0 (leading), the result is the number of mask-set positions above the highest bit of (src AND mask) that is set.
- R3: With `in_trail` = 1 (trailing), the result is the number of mask-set positions below the lowest bit of (src AND mask) that is set.
- R4: When src AND mask is all zeros, the result in both directions equals the number of ones in the mask. An all-zero mask therefore gives 0, and an all-ones mask gives 64.
- R5: A result of 0 is produced when the first selected position already holds a one. This means bit 63 for leading and bit 0 for trailing.
- R6: `out_count` bits 63..7 are always 0, and the value never exceeds 64.
- R7: An input transfer makes `out_valid` high on the following clock edge, carrying that operand's result.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_count` hold and `in_ready` is low.
- R9: While `rst_n` is low, `out_valid` is 0, `out_count` is 0 and `in_ready` is 1.
- R10: When a result is consumed and no new input is transferred on the same edge, `out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operand present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_src | input | 64 | Operand whose zeros are counted |
| in_mask | input | 64 | Selects which positions take part |
| in_trail | input | 1 | 0: count from bit 63 down; 1: count from bit 0 up |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_count | output | 64 | Zero-extended count, 0 to 64 |

## Verification
The counting path has no state. A fault there shows up in `out_count` in the cycle right after the operand is transferred. Each such fault shows only for particular operand patterns. For example, a wrong reversal shows only on trailing operands, and a wrong shift shows only when the first selected one sits away from the word ends.

Faults in the output register show up as a result that changes while stalled, a duplicated or lost `out_valid`, or `in_ready` staying high under a stall. These appear within one or two cycles of a stall or a drain. The bench therefore checks random operands against a bit-serial reference, and it also stalls and drains the output stage on purpose.

// File: rtl/mzc_pkg.sv
`timescale 1ns/1ps
package mzc_pkg;
  localparam int unsigned MZC_WIDTH = 64;

  // Counting direction; the encoding matches the in_trail pin.
  typedef enum logic {
    MZC_LEAD  = 1'b0,
    MZC_TRAIL = 1'b1
  } mzc_dir_e;

  function automatic int unsigned mzc_cnt_w(input int unsigned w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/mzc_lzc.sv
`timescale 1ns/1ps
// Leading-zero count. An all-zero input gives W.
module mzc_lzc #(
  parameter int unsigned W  = 64,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  always_comb begin
    zeros = CW'(W);
    // The highest set bit is visited last, so it decides the count.
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/mzc_shr.sv
`timescale 1ns/1ps
// Logarithmic right shifter. Any amount of W or more clears the word.
module mzc_shr #(
  parameter int unsigned W  = 64,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [CW+1];
  assign stage[0] = din;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam longint unsigned STEP = 64'd1 << k;
    if (STEP < W) begin : g_shift
      assign stage[k+1] = amt[k] ? (stage[k] >> STEP) : stage[k];
    end else begin : g_clear
      assign stage[k+1] = amt[k] ? '0 : stage[k];
    end
  end

  assign dout = stage[CW];
endmodule

// File: rtl/mzc_popcnt.sv
`timescale 1ns/1ps
// Counts the ones in a word using a pairwise adder tree.
module mzc_popcnt #(
  parameter int unsigned W  = 64,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] ones
);
  localparam int unsigned LVLS = (W > 1) ? $clog2(W) : 1;
  localparam int unsigned LEAF = 1 << LVLS;

  logic [CW-1:0] node [2*LEAF];

  for (genvar l = 0; l < LEAF; l++) begin : g_leaf
    if (l < W) begin : g_bit
      assign node[LEAF + l] = CW'(vec[l]);
    end else begin : g_pad
      assign node[LEAF + l] = '0;
    end
  end

  for (genvar n = 1; n < LEAF; n++) begin : g_sum
    assign node[n] = node[2*n] + node[2*n + 1];
  end

  assign node[0] = '0;
  assign ones    = node[1];
endmodule

// File: rtl/mzc_core.sv
`timescale 1ns/1ps
// Combinational masked zero count. The trailing direction bit-reverses
// both words, so a single leading-direction datapath serves both ends.
module mzc_core
  import mzc_pkg::*;
#(
  parameter int unsigned W  = MZC_WIDTH,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  mask,
  input  mzc_dir_e      dir,
  output logic [CW-1:0] count
);
  logic [W-1:0]  sel, sel_rev, mask_rev;
  logic [W-1:0]  sel_n, mask_n;
  logic [W-1:0]  beyond;
  logic [CW-1:0] raw, shamt, pc;

  assign sel = src & mask;

  for (genvar g = 0; g < W; g++) begin : g_rev
    assign sel_rev[g]  = sel[W-1-g];
    assign mask_rev[g] = mask[W-1-g];
  end

  assign sel_n  = (dir == MZC_TRAIL) ? sel_rev  : sel;
  assign mask_n = (dir == MZC_TRAIL) ? mask_rev : mask;

  mzc_lzc #(.W(W), .CW(CW)) u_lzc (
    .vec   (sel_n),
    .zeros (raw)
  );

  // Keep only the top `raw` mask bits: the ones ahead of the first hit.
  assign shamt = CW'(W) - raw;

  mzc_shr #(.W(W), .CW(CW)) u_shr (
    .din  (mask_n),
    .amt  (shamt),
    .dout (beyond)
  );

  mzc_popcnt #(.W(W), .CW(CW)) u_pop (
    .vec  (beyond),
    .ones (pc)
  );

  assign count = (raw == '0) ? '0 : pc;
endmodule

// File: rtl/mzc_unit.sv
`timescale 1ns/1ps
// Stream wrapper: one output register with pass-through ready.
module mzc_unit
  import mzc_pkg::*;
#(
  parameter int unsigned W     = MZC_WIDTH,
  parameter int unsigned OUT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_src,
  input  logic [W-1:0]     in_mask,
  input  logic             in_trail,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_count
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] cnt_d, cnt_q;
  logic          vld_q;
  logic          take;
  mzc_dir_e      dir;

  assign dir = mzc_dir_e'(in_trail);

  mzc_core #(.W(W), .CW(CW)) u_core (
    .src   (in_src),
    .mask  (in_mask),
    .dir   (dir),
    .count (cnt_d)
  );

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (in_ready) vld_q <= in_valid;
      if (take)     cnt_q <= cnt_d;
    end
  end

  assign out_valid = vld_q;
  assign out_count = OUT_W'(cnt_q);
endmodule

// File: rtl/mzc_unit_chk.sv
`timescale 1ns/1ps
module mzc_unit_chk #(
  parameter int unsigned W     = 64,
  parameter int unsigned OUT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [W-1:0]     in_src,
  input logic [W-1:0]     in_mask,
  input logic             in_trail,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_count
);
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_count)));

  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count[OUT_W-1:7] == '0 && out_count[6:0] <= 7'd64));

  a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  a_r4_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mask == '0) |=> (out_count == '0));

  a_r5_lead_top: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_trail && in_src[W-1] && in_mask[W-1])
      |=> (out_count == '0));

  a_r5_trail_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_trail && in_src[0] && in_mask[0])
      |=> (out_count == '0));
endmodule

bind mzc_unit mzc_unit_chk #(.W(W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/mzc_unit_tb.sv
`timescale 1ns/1ps
module mzc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic [63:0] in_mask = '0;
  logic        in_trail = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_count;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  mzc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_mask(in_mask), .in_trail(in_trail),
    .out_valid(out_valid), .out_ready(out_ready), .out_count(out_count)
  );

  localparam int NV = 12;
  localparam logic [63:0] T_SRC [NV] = '{
    64'h0, 64'h0, 64'h1, 64'h1,
    64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hF0, 64'h100, 64'h100,
    64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0000};
  localparam logic [63:0] T_MSK [NV] = '{
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0, 64'h0F, 64'h0F0F, 64'h0F0F,
    64'h5555_5555_5555_5555, 64'h7FFF_FFFF_FFFF_FFFF};
  localparam logic T_TRL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
                                  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [63:0] T_EXP [NV] = '{
    64'd64, 64'd64, 64'd63, 64'd0, 64'd0, 64'd63,
    64'd0, 64'd4, 64'd4, 64'd3, 64'd1, 64'd63};
  localparam string T_REQ [NV] = '{"R4", "R4", "R2", "R5", "R5", "R3",
                                   "R1", "R4", "R3", "R2", "R3", "R4"};

  function automatic logic [63:0] ref_count(input logic [63:0] s,
                                            input logic [63:0] m,
                                            input logic t);
    int n = 0;
    for (int k = 0; k < 64; k++) begin
      int idx = t ? k : 63 - k;
      if (s[idx] && m[idx]) break;
      if (m[idx]) n++;
    end
    return 64'(n);
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)",
               req, act, act, exp, exp);
    end
  endtask

  // One transfer with the consumer always ready; samples one cycle later.
  task automatic run_one(input logic [63:0] s, input logic [63:0] m,
                         input logic t, output logic v,
                         output logic [63:0] got);
    @(negedge clk);
    in_src = s; in_mask = m; in_trail = t; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    v = out_valid; got = out_count;
    in_valid = 1'b0;
  endtask

  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;
  function automatic logic [63:0] nxt(input logic [63:0] x);
    logic [63:0] y = x;
    y ^= y << 13; y ^= y >> 7; y ^= y << 17;
    return y;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R7: watchdog expired, actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic v;
    logic [63:0] got, got2, a_exp, b_exp;

    repeat (3) @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd0);
    check("R9", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      run_one(T_SRC[i], T_MSK[i], T_TRL[i], v, got);
      check("R7", {63'd0, v}, 64'd1);
      check(T_REQ[i], got, T_EXP[i]);
    end

    // Random operands against the bit-serial reference; masks of varied density
    for (int i = 0; i < 300; i++) begin
      logic [63:0] s, m;
      logic t;
      rs = nxt(rs); s = rs;
      rs = nxt(rs); m = rs;
      if (i % 3 == 1) begin rs = nxt(rs); m = m & rs; end
      if (i % 3 == 2) begin rs = nxt(rs); s = s & rs & (rs >> 5); end
      rs = nxt(rs); t = rs[0];
      run_one(s, m, t, v, got);
      check(t ? "R3" : "R2", got, ref_count(s, m, t));
      check("R6", {57'd0, got[63:57]} | (got > 64 ? 64'd1 : 64'd0), 64'd0);
    end

    // R1: setting every unmasked source bit leaves the result unchanged
    for (int i = 0; i < 8; i++) begin
      logic [63:0] s, m;
      rs = nxt(rs); s = rs & (rs >> 3);
      rs = nxt(rs); m = rs;
      run_one(s, m, i[0], v, got);
      run_one(s | ~m, m, i[0], v, got2);
      check("R1", got2, got);
    end

    // Single set bit at either end, all-ones mask
    run_one(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, v, got);
    check("R5", got, 64'd0);
    run_one(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, v, got);
    check("R5", got, 64'd0);
    run_one(64'h0, 64'h0, 1'b1, v, got);
    check("R4", got, 64'd0);

    // R10: drained with no new input
    @(negedge clk);
    check("R10", {63'd0, out_valid}, 64'd0);

    // R8: stall holds the result and blocks input, then resumes
    a_exp = ref_count(64'h0000_0400_0000_0000, 64'hF0F0_F0F0_F0F0_F0F0, 1'b0);
    b_exp = ref_count(64'h0000_0000_0001_0000, 64'h3333_3333_3333_3333, 1'b1);
    @(negedge clk);
    out_ready = 1'b0;
    in_src = 64'h0000_0400_0000_0000; in_mask = 64'hF0F0_F0F0_F0F0_F0F0;
    in_trail = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R7", {63'd0, out_valid}, 64'd1);
    check("R2", out_count, a_exp);
    in_src = 64'h0000_0000_0001_0000; in_mask = 64'h3333_3333_3333_3333;
    in_trail = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R8", {63'd0, in_ready}, 64'd0);
      check("R8", {63'd0, out_valid}, 64'd1);
      check("R8", out_count, a_exp);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R8", {63'd0, out_valid}, 64'd1);
    check("R3", out_count, b_exp);
    in_valid = 1'b0;
    @(negedge clk);
    check("R10", {63'd0, out_valid}, 64'd0);

    // R9: reset while a result is held
    out_ready = 1'b0;
    in_src = 64'h0; in_mask = 64'hFF; in_trail = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", {63'd0, out_valid}, 64'd1);
    rst_n = 1'b0;
    #1;
    check("R9", {63'd0, out_valid}, 64'd0);
    check("R9", out_count, 64'd0);
    check("R9", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule